// File: doc/BRIEF.md
# Conversion Pulse Sequencer for Clockless SAR Converter Banks

This block paces a bank of dual-channel 16-bit SAR converters that have no clock of their own. One conversion-start output is shared by every converter package. Both channels of a package therefore start converting at the same edge. The spacing between two starts is the only control over the sample rate. A single 18-bit length value sets that spacing for all 40 channels. It is held in a register outside this block and arrives here as the `periodLen` input.

The block runs from a 210 MHz clock. One period lasts 42 + `periodLen` clock cycles, so a length of zero gives the fastest rate, 5 MHz. Lengths above the largest legal value are clamped to it, which gives 1 kHz.

In each period the block proceeds in fixed steps:
- It raises the start pulse for a few cycles.
- It waits out the conversion time.
- It runs a serial clock at half the core clock for exactly 16 bits. Each channel has its own data line, read most significant bit first.
- It presents all 40 results together with a one-cycle valid strobe.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While `rstN` is low, `convOut`, `sclkOut` and `sampleValid` are low and `sampleData` is zero. The first period begins in the cycle after the first rising clock edge at which `rstN` is high, and that period is 42 cycles long.
- R2: For a length value L not above `MAX_LEN`, the distance between two rising edges of `convOut` is 42 + L clock cycles.
- R3: A length value of 0 gives the shortest period, 42 clock cycles.
- R4: A length value above `MAX_LEN` acts as `MAX_LEN`. With the default `MAX_LEN` of 209958 this is 210000 cycles, or 1 kHz at 210 MHz.
- R5: `periodLen` is sampled only at the clock edge that ends a period, and that sample sets the length of the period that follows. A change at any earlier point of a running period does not alter that period.
- R6: `convOut` is high for exactly `PULSE_CYC` (default 4) cycles, namely cycles 0 to 3 of every period.
- R7: `sclkOut` is high only in cycles 10, 12, ..., 40 of a period: 16 high cycles, each followed by a low cycle. It is never high while `convOut` is high.
- R8: Each channel line `sdataIn[c]` is captured at the clock edge that ends every high cycle of `sclkOut`, and the first captured bit is the most significant. The 16-bit result of channel c appears at `sampleData[16*c+15 : 16*c]`.
- R9: `sampleValid` is high for one cycle, cycle 41 of the period, which is the cycle after the last bit is captured. `sampleData` takes its new value in that same cycle and holds it until the next valid cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 210 MHz core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| periodLen | input | 18 | Period length added to the 42-cycle minimum |
| sdataIn | input | 40 | One serial data line per converter channel |
| convOut | output | 1 | Conversion start pulse shared by all converters |
| sclkOut | output | 1 | Serial readout clock, half the core clock during readout |
| sampleData | output | 640 | All channel results, channel c at bits 16c+15..16c |
| sampleValid | output | 1 | One-cycle strobe marking a new set of results |

## Verification
At the shortest period, the cycle that finishes the readout and raises `sampleValid` is also the last cycle of the period. In that cycle the next length value is sampled. The bench changes `periodLen` in exactly that cycle. It then judges against its reference model that the new length governs the period that has just started, and that the result set delivered in the same cycle is complete and correct. A length change written in the middle of a period is also applied. The measured gap between start pulses must still equal the old length.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Strobes from the sequencing control into the capture datapath
  typedef struct packed {
    logic shiftEn;  // a serial clock high phase ends at this edge
    logic lastBit;  // this edge captures the final bit of a sample
  } seqStrobe_t;

endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import seq_pkg::*;
#(
  parameter int LEN_W      = 18,
  parameter int MIN_PERIOD = 42,
  parameter int MAX_LEN    = 209958,
  parameter int PULSE_CYC  = 4,
  parameter int CONV_CYC   = 10,
  parameter int SAMPLE_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] periodLen,
  output logic             convOut,
  output logic             sclkOut,
  output seqStrobe_t       strobes
);

  localparam int CNT_W  = $clog2(MIN_PERIOD + MAX_LEN + 1);
  localparam int RD_LEN = 2 * SAMPLE_W;
  localparam int RD_END = CONV_CYC + RD_LEN;

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] lastPhase;
  logic             armed;
  logic [LEN_W-1:0] clampedLen;
  logic [CNT_W-1:0] nextLast;
  logic [CNT_W-1:0] bitPhase;
  logic             inWindow;

  // Limit the length to the slowest legal rate
  always_comb begin
    if (periodLen > LEN_W'(MAX_LEN)) clampedLen = LEN_W'(MAX_LEN);
    else                             clampedLen = periodLen;
    nextLast = CNT_W'(MIN_PERIOD - 1) + CNT_W'(clampedLen);
  end

  // Period counter; the length is taken over only when a period ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      phaseCnt  <= '0;
      lastPhase <= CNT_W'(MIN_PERIOD - 1);
    end else if (!armed) begin
      armed <= 1'b1;
    end else if (phaseCnt == lastPhase) begin
      phaseCnt  <= '0;
      lastPhase <= nextLast;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_comb begin
    inWindow = armed && (phaseCnt >= CNT_W'(CONV_CYC)) && (phaseCnt < CNT_W'(RD_END));
    bitPhase = phaseCnt - CNT_W'(CONV_CYC);
    convOut  = armed && (phaseCnt < CNT_W'(PULSE_CYC));
    sclkOut  = inWindow && !bitPhase[0];
    strobes.shiftEn = sclkOut;
    strobes.lastBit = sclkOut && (phaseCnt == CNT_W'(RD_END - 2));
  end

endmodule

// File: rtl/sample_capture.sv
module sample_capture
  import seq_pkg::*;
#(
  parameter int NUM_CH   = 40,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 strobes,
  input  logic [NUM_CH-1:0]          sdataIn,
  output logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  output logic                       sampleValid
);

  logic [NUM_CH-1:0][SAMPLE_W-1:0] shiftReg;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] capWord;

  // Serial shift per channel, MSB arrives first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.shiftEn) begin
      for (int ch = 0; ch < NUM_CH; ch++)
        shiftReg[ch] <= {shiftReg[ch][SAMPLE_W-2:0], sdataIn[ch]};
    end
  end

  // Whole result set is updated at once with the final bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capWord     <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.lastBit;
      if (strobes.lastBit) begin
        for (int ch = 0; ch < NUM_CH; ch++)
          capWord[ch] <= {shiftReg[ch][SAMPLE_W-2:0], sdataIn[ch]};
      end
    end
  end

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_out
    assign sampleData[gc*SAMPLE_W +: SAMPLE_W] = capWord[gc];
  end

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_PKG    = 20,
  parameter int SAMPLE_W   = 16,
  parameter int LEN_W      = 18,
  parameter int MIN_PERIOD = 42,
  parameter int MAX_LEN    = 209958,
  parameter int PULSE_CYC  = 4,
  parameter int CONV_CYC   = 10,
  localparam int NUM_CH    = 2 * NUM_PKG
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [LEN_W-1:0]           periodLen,
  input  logic [NUM_CH-1:0]          sdataIn,
  output logic                       convOut,
  output logic                       sclkOut,
  output logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  output logic                       sampleValid
);

  seqStrobe_t ctrlStrobes;

  conv_ctrl #(
    .LEN_W(LEN_W), .MIN_PERIOD(MIN_PERIOD), .MAX_LEN(MAX_LEN),
    .PULSE_CYC(PULSE_CYC), .CONV_CYC(CONV_CYC), .SAMPLE_W(SAMPLE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .periodLen(periodLen),
    .convOut(convOut), .sclkOut(sclkOut), .strobes(ctrlStrobes)
  );

  sample_capture #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)
  ) u_cap (
    .clk(clk), .rstN(rstN), .strobes(ctrlStrobes), .sdataIn(sdataIn),
    .sampleData(sampleData), .sampleValid(sampleValid)
  );

endmodule

// File: rtl/adc_conv_sequencer_chk.sv
module adc_conv_sequencer_chk #(
  parameter int NUM_CH     = 40,
  parameter int SAMPLE_W   = 16,
  parameter int MIN_PERIOD = 42,
  parameter int MAX_LEN    = 209958,
  parameter int PULSE_CYC  = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       convOut,
  input logic                       sclkOut,
  input logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  input logic                       sampleValid
);

  logic convPrev;
  logic riseSeen;
  int   convRun;
  int   gapCnt;
  int   shiftCnt;
  logic convRise;

  assign convRise = convOut && !convPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convPrev <= 1'b0;
      riseSeen <= 1'b0;
      convRun  <= 0;
      gapCnt   <= 0;
      shiftCnt <= 0;
    end else begin
      convPrev <= convOut;
      riseSeen <= riseSeen || convRise;
      convRun  <= convOut ? convRun + 1 : 0;
      gapCnt   <= convRise ? 0 : gapCnt + 1;
      shiftCnt <= convRise ? 0 : shiftCnt + (sclkOut ? 1 : 0);
    end
  end

  // R6: start pulse is exactly PULSE_CYC cycles wide
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convOut) |-> (convRun == PULSE_CYC));

  a_r6_pulse_not_long: assert property (@(posedge clk) disable iff (!rstN)
    convOut |-> (convRun < PULSE_CYC));

  // R2: spacing of start pulses stays within the legal range
  a_r2_period_range: assert property (@(posedge clk) disable iff (!rstN)
    (convRise && riseSeen) |-> ((gapCnt + 1 >= MIN_PERIOD) && (gapCnt + 1 <= MIN_PERIOD + MAX_LEN)));

  // R7: serial clock never overlaps the start pulse and alternates
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(convOut && sclkOut));

  a_r7_sclk_toggle: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut |=> !sclkOut);

  // R9: valid is a single cycle after exactly SAMPLE_W serial clocks
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  a_r9_bits_per_sample: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (shiftCnt == SAMPLE_W));

  // R8: results only change together with the valid strobe
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sampleData) |-> sampleValid);

endmodule

bind adc_conv_sequencer adc_conv_sequencer_chk #(
  .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .MIN_PERIOD(MIN_PERIOD),
  .MAX_LEN(MAX_LEN), .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .convOut(convOut), .sclkOut(sclkOut),
  .sampleData(sampleData), .sampleValid(sampleValid)
);

// File: tb/adc_conv_sequencer_bench.sv
module adc_conv_sequencer_bench;

  localparam int CLK_PERIOD = 4;
  localparam int NCH        = 40;
  localparam int SW         = 16;
  localparam int MINP       = 42;
  localparam int MAXL       = 60;
  localparam int PULSE      = 4;
  localparam int CONV       = 10;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [17:0]         periodLen = '0;
  logic [NCH-1:0]      sdataIn = '0;
  logic                convOut;
  logic                sclkOut;
  logic [NCH*SW-1:0]   sampleData;
  logic                sampleValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  adc_conv_sequencer #(.MAX_LEN(MAXL)) u_adc_conv_sequencer (
    .clk(clk), .rstN(rstN), .periodLen(periodLen), .sdataIn(sdataIn),
    .convOut(convOut), .sclkOut(sclkOut), .sampleData(sampleData),
    .sampleValid(sampleValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Converter model: new words at each start pulse, next bit on falling sclk
  int sampleNo = 0;
  int bitIdx   = 16;
  logic [SW-1:0] curWord [NCH];

  function automatic logic [SW-1:0] mkWord(int s, int c);
    return SW'(s * 40503 + c * 12059 + 777) ^ SW'(c << 11);
  endfunction

  task automatic driveLines();
    for (int c = 0; c < NCH; c++)
      sdataIn[c] = (bitIdx < SW) ? curWord[c][SW-1-bitIdx] : 1'b0;
  endtask

  always @(posedge convOut) begin
    sampleNo++;
    for (int c = 0; c < NCH; c++) curWord[c] = mkWord(sampleNo, c);
    bitIdx = 0;
    driveLines();
  end

  always @(negedge sclkOut) begin
    bitIdx++;
    driveLines();
  end

  // Behavioural reference of the period position
  bit started = 0;
  int pos     = 0;
  int per     = MINP;

  always @(posedge clk) begin
    if (!rstN) begin
      started = 0; pos = 0; per = MINP;
    end else if (!started) begin
      started = 1; pos = 0; per = MINP;
    end else if (pos == per - 1) begin
      pos = 0;
      per = MINP + ((int'(periodLen) > MAXL) ? MAXL : int'(periodLen));
    end else begin
      pos++;
    end
  end

  // Compare on every falling clock edge
  logic [NCH*SW-1:0] expData = '0;
  string periodTag = "R1";
  bit prevConv = 0;
  bit haveRise = 0;
  int cyc = 0;
  int lastRiseCyc = 0;
  int lastPer = MINP;

  always @(negedge clk) begin
    bit expConv, expSclk, expValid;
    cyc++;
    expConv  = started && pos < PULSE;
    expSclk  = started && pos >= CONV && pos < CONV + 2*SW && ((pos - CONV) % 2 == 0);
    expValid = started && pos == CONV + 2*SW - 1;
    if (expValid)
      for (int c = 0; c < NCH; c++) expData[c*SW +: SW] = curWord[c];
    if (!rstN) begin
      check(!convOut && !sclkOut && !sampleValid && sampleData == '0, "R1", "outputs in reset",
            longint'({convOut, sclkOut, sampleValid}), 0);
    end else begin
      check(convOut == expConv, "R6", "convOut", convOut, expConv);
      check(sclkOut == expSclk, "R7", "sclkOut", sclkOut, expSclk);
      check(sampleValid == expValid, "R9", "sampleValid", sampleValid, expValid);
      if (sampleData != expData) begin
        for (int c = 0; c < NCH; c++)
          if (sampleData[c*SW +: SW] != expData[c*SW +: SW])
            $display("  channel %0d actual %h expected %h", c, sampleData[c*SW +: SW], expData[c*SW +: SW]);
      end
      check(sampleData == expData, "R8", "sampleData word 0",
            longint'(sampleData[SW-1:0]), longint'(expData[SW-1:0]));
      if (convOut && !prevConv) begin
        if (haveRise)
          check(cyc - lastRiseCyc == lastPer, periodTag, "pulse spacing",
                cyc - lastRiseCyc, lastPer);
        haveRise    = 1;
        lastRiseCyc = cyc;
        lastPer     = per;
      end
    end
    prevConv = convOut;
  end

  task automatic waitPos(input int p);
    do @(negedge clk); while (pos != p);
  endtask

  task automatic periods(input int n);
    for (int i = 0; i < n; i++) begin
      waitPos(1);
      waitPos(0);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    periodTag = "R3";
    periods(4);
    // mid-period change must not alter the running period (R5)
    periodTag = "R5";
    waitPos(20);
    periodLen = 18'd5;
    waitPos(0);
    periodTag = "R2";
    periods(3);
    periodLen = 18'd17;
    periods(3);
    // change exactly in the final cycle of a period, same cycle as valid (R5)
    periodTag = "R5";
    waitPos(per - 1);
    periodLen = 18'd0;
    periods(3);
    waitPos(MINP - 1);
    periodLen = 18'd3;
    periods(3);
    // clamp above the maximum (R4)
    periodTag = "R4";
    periodLen = 18'h3FFFF;
    periods(3);
    periodLen = 18'(MAXL);
    periods(2);
    periodLen = 18'(MAXL + 1);
    periods(2);
    periodTag = "R3";
    periodLen = 18'd0;
    periods(3);
    done = 1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      finishRun();
    end
  end

endmodule